// File: doc/BRIEF.md
# Processor clock-stop wake event controller

This block holds the processor in a low-power clock-control state. Software requests entry with a one-cycle pulse. The stop-clock output then stays asserted until a qualified wake event occurs. Wake sources come in classes, and each class has its own bit in a 6-bit activity-enable register. The timer interrupt (IRQ0) and the real-time clock interrupt (IRQ8) each have a bit of their own. The other maskable interrupts share a bit with NMI and INIT, and a fourth bit covers the power-management inputs. A fully wake-capable configuration therefore needs the IRQ0, general-IRQ and RTC bits all set. If the RTC bit is left clear, RTC interrupts are serviced late.

A separate enable bit lets keyboard (IRQ1) or mouse (IRQ12) activity reload a global standby down-counter. This bit never wakes the processor. The counter raises a one-cycle expiry flag when it reaches zero. All asynchronous event inputs pass through a parameterised synchroniser before they are qualified.

The controller has two states, RUN and STOP. The transition RUN→STOP ("enter") is taken on `sleep_req`. The transition STOP→RUN ("break") is taken on a qualified break event. In RUN the break logic is ignored. In STOP the sleep request is ignored.

Top module: `clkstop_wake_ctrl`

## Requirements
- R1: After reset the block is in RUN, with `stpclk_o`, `wake_o` and `gst_expire_o` low, `cfg_rdata` zero and `gst_count_o` zero.
- R2: A `sleep_req` pulse in RUN raises `stpclk_o` at the next clock edge, and it stays high until a break event is seen.
- R3: With enable bit 0 set, an unmasked IRQ0 (`irq_req[0]` high, `irq_mask[0]` low) is a break event.
- R4: With enable bit 1 set, an unmasked assertion on IRQ1, IRQ3–IRQ7 or IRQ9–IRQ15 is a break event, and so is NMI or INIT. IRQ2 is never a break event.
- R5: With enable bit 5 set, an unmasked IRQ8 (real-time clock) is a break event. IRQ8 is not covered by bit 1.
- R6: With enable bit 4 set, any bit of `pme_req` is a break event. The bits are [0] SMI, [1] GPI1, [2] power button, [3] lid, all active high.
- R7: A source whose mask bit is 1, or whose class enable bit is 0, leaves the block in STOP.
- R8: Bit 3 of the enable register ignores writes and reads 0. Bits 0, 1, 2, 4 and 5 read back as written.
- R9: A break input that rises before clock edge k lowers `stpclk_o` at edge k+SYNC_STAGES. `wake_o` is high for exactly that one cycle.
- R10: With enable bit 2 set, an asserted IRQ1 or IRQ12 reloads the standby counter from its reload value on every cycle. Bit 2 alone never causes a break.
- R11: A `tmr_we` write loads both the reload value and the counter. The counter then decrements once per cycle. `gst_expire_o` pulses for one cycle when the counter reaches zero, and the counter then stays at zero.
- R12: In RUN, break events have no effect: `wake_o` stays low and `stpclk_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the enable register |
| cfg_wdata | input | 6 | Enable register write data |
| cfg_rdata | output | 6 | Enable register read data |
| tmr_we | input | 1 | Write strobe for the standby reload value |
| tmr_wdata | input | TMR_W | Standby reload value |
| sleep_req | input | 1 | One-cycle request to enter STOP |
| irq_req | input | 16 | Interrupt request lines IRQ0–IRQ15 |
| irq_mask | input | 16 | Per-line mask, 1 = masked |
| nmi_req | input | 1 | Non-maskable interrupt |
| init_req | input | 1 | Processor INIT request |
| pme_req | input | 4 | Power-management events: SMI, GPI1, power button, lid |
| stpclk_o | output | 1 | Stop-clock to the processor |
| wake_o | output | 1 | One-cycle pulse on leaving STOP |
| gst_expire_o | output | 1 | One-cycle standby counter expiry |
| gst_count_o | output | TMR_W | Current standby counter value |

## Verification
The bench builds the block with SYNC_STAGES=2 and TMR_W=16. At these values the break latency is a fixed three edges, and short reload values reach expiry within a few cycles. This makes a full sweep possible: all 64 enable codes against each of the 22 individual sources. Each combination is checked both for the exact wake cycle and for the absence of a wake. Mask sweeps, RUN-state immunity, and counter reload, hold and expiry at these settings cover the remaining corners.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;
    typedef enum logic [0:0] {
        CS_RUN  = 1'b0,
        CS_STOP = 1'b1
    } cs_state_e;

    localparam int EN_W     = 6;
    localparam int NUM_IRQ  = 16;
    localparam int NUM_PME  = 4;

    // enable register bit positions (software-visible encoding)
    localparam int EN_IRQ0  = 0;
    localparam int EN_IRQ   = 1;
    localparam int EN_KBMS  = 2;
    localparam int EN_RSVD  = 3;
    localparam int EN_PME   = 4;
    localparam int EN_RTC   = 5;

    localparam int IRQ_TMR  = 0;
    localparam int IRQ_KBD  = 1;
    localparam int IRQ_CASC = 2;
    localparam int IRQ_RTC  = 8;
    localparam int IRQ_MOUSE = 12;
endpackage

// File: rtl/clkstop_sync.sv
module clkstop_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[0] <= '0;
        else        pipe[0] <= d;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe[s] <= '0;
                else        pipe[s] <= pipe[s-1];
            end
        end
    endgenerate

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/clkstop_qualify.sv
module clkstop_qualify
    import clkstop_pkg::*;
(
    input  logic [EN_W-1:0]    en,
    input  logic [NUM_IRQ-1:0] irq_s,
    input  logic [NUM_IRQ-1:0] irq_mask,
    input  logic               nmi_s,
    input  logic               init_s,
    input  logic [NUM_PME-1:0] pme_s,
    output logic               brk,
    output logic               kbms_act
);
    logic [NUM_IRQ-1:0] live;
    logic               gen_irq;

    assign live = irq_s & ~irq_mask;

    always_comb begin
        gen_irq = nmi_s | init_s;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (i != IRQ_TMR && i != IRQ_CASC && i != IRQ_RTC)
                gen_irq = gen_irq | live[i];
        end
    end

    always_comb begin
        brk = 1'b0;
        if (en[EN_IRQ0] && live[IRQ_TMR]) brk = 1'b1;
        if (en[EN_IRQ]  && gen_irq)       brk = 1'b1;
        if (en[EN_RTC]  && live[IRQ_RTC]) brk = 1'b1;
        if (en[EN_PME]  && (|pme_s))      brk = 1'b1;
    end

    assign kbms_act = en[EN_KBMS] & (irq_s[IRQ_KBD] | irq_s[IRQ_MOUSE]);
endmodule

// File: rtl/clkstop_standby_timer.sv
module clkstop_standby_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         act_reload,
    output logic [W-1:0] count,
    output logic         expire
);
    logic [W-1:0] reload_q;
    logic [W-1:0] count_q;
    logic         expire_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reload_q <= '0;
            count_q  <= '0;
            expire_q <= 1'b0;
        end else begin
            expire_q <= 1'b0;
            if (wr) begin
                reload_q <= wdata;
                count_q  <= wdata;
            end else if (act_reload) begin
                count_q  <= reload_q;
            end else if (count_q != '0) begin
                count_q  <= count_q - 1'b1;
                expire_q <= (count_q == W'(1));
            end
        end
    end

    assign count  = count_q;
    assign expire = expire_q;

    a_r11_expire_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        expire_q |-> (count_q == '0));
    a_r11_expire_single: assert property (@(posedge clk) disable iff (!rst_n)
        expire_q |=> !expire_q);
endmodule

// File: rtl/clkstop_wake_ctrl.sv
module clkstop_wake_ctrl
    import clkstop_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int TMR_W       = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [5:0]         cfg_wdata,
    output logic [5:0]         cfg_rdata,
    input  logic               tmr_we,
    input  logic [TMR_W-1:0]   tmr_wdata,
    input  logic               sleep_req,
    input  logic [15:0]        irq_req,
    input  logic [15:0]        irq_mask,
    input  logic               nmi_req,
    input  logic               init_req,
    input  logic [3:0]         pme_req,
    output logic               stpclk_o,
    output logic               wake_o,
    output logic               gst_expire_o,
    output logic [TMR_W-1:0]   gst_count_o
);
    localparam int SYNC_W = NUM_IRQ + 2 + NUM_PME;
    localparam logic [EN_W-1:0] EN_KEEP = ~(EN_W'(1) << EN_RSVD);

    logic [EN_W-1:0]   en_q;
    logic [SYNC_W-1:0] raw_ev;
    logic [SYNC_W-1:0] syn_ev;
    logic              brk;
    logic              kbms_act;
    cs_state_e         state_q;
    cs_state_e         state_d;
    logic              stpclk_q;
    logic              wake_q;

    // enable register; reserved bit never stored
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      en_q <= '0;
        else if (cfg_we) en_q <= cfg_wdata & EN_KEEP;
    end
    assign cfg_rdata = en_q;

    assign raw_ev = {pme_req, init_req, nmi_req, irq_req};

    clkstop_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_ev),
        .q     (syn_ev)
    );

    clkstop_qualify u_qual (
        .en       (en_q),
        .irq_s    (syn_ev[NUM_IRQ-1:0]),
        .irq_mask (irq_mask),
        .nmi_s    (syn_ev[NUM_IRQ]),
        .init_s   (syn_ev[NUM_IRQ+1]),
        .pme_s    (syn_ev[SYNC_W-1 -: NUM_PME]),
        .brk      (brk),
        .kbms_act (kbms_act)
    );

    clkstop_standby_timer #(.W(TMR_W)) u_gst (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (tmr_we),
        .wdata      (tmr_wdata),
        .act_reload (kbms_act),
        .count      (gst_count_o),
        .expire     (gst_expire_o)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CS_RUN;
        else        state_q <= state_d;
    end

    // transitions: enter (RUN->STOP), break (STOP->RUN)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CS_RUN:  if (sleep_req) state_d = CS_STOP;
            CS_STOP: if (brk)       state_d = CS_RUN;
            default: state_d = CS_RUN;
        endcase
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stpclk_q <= 1'b0;
            wake_q   <= 1'b0;
        end else begin
            stpclk_q <= (state_d == CS_STOP);
            wake_q   <= (state_q == CS_STOP) && (state_d == CS_RUN);
        end
    end

    assign stpclk_o = stpclk_q;
    assign wake_o   = wake_q;

    a_r2_enter: assert property (@(posedge clk) disable iff (!rst_n)
        (!stpclk_o && sleep_req) |=> stpclk_o);
    a_r7_hold_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (stpclk_o && !brk) |=> stpclk_o);
    a_r9_wake_single: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |=> !wake_o);
    a_r9_wake_on_exit: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> (!stpclk_o && $past(stpclk_o)));
    a_r12_no_wake_running: assert property (@(posedge clk) disable iff (!rst_n)
        !stpclk_o |=> !wake_o);
endmodule

// File: tb/clkstop_wake_ctrl_tb.sv
module clkstop_wake_ctrl_tb;
    localparam int CLK_P = 10;
    localparam int TW    = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cfg_we;
    logic [5:0]    cfg_wdata;
    logic [5:0]    cfg_rdata;
    logic          tmr_we;
    logic [TW-1:0] tmr_wdata;
    logic          sleep_req;
    logic [15:0]   irq_req;
    logic [15:0]   irq_mask;
    logic          nmi_req;
    logic          init_req;
    logic [3:0]    pme_req;
    logic          stpclk_o;
    logic          wake_o;
    logic          gst_expire_o;
    logic [TW-1:0] gst_count_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    clkstop_wake_ctrl #(.SYNC_STAGES(2), .TMR_W(TW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .tmr_we(tmr_we), .tmr_wdata(tmr_wdata),
        .sleep_req(sleep_req), .irq_req(irq_req), .irq_mask(irq_mask),
        .nmi_req(nmi_req), .init_req(init_req), .pme_req(pme_req),
        .stpclk_o(stpclk_o), .wake_o(wake_o), .gst_expire_o(gst_expire_o),
        .gst_count_o(gst_count_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic clear_src();
        irq_req = '0; nmi_req = 1'b0; init_req = 1'b0; pme_req = '0;
    endtask

    task automatic do_reset();
        cfg_we = 0; cfg_wdata = '0; tmr_we = 0; tmr_wdata = '0;
        sleep_req = 0; irq_mask = '0;
        clear_src();
        rst_n = 1'b0;
        step(2);
        rst_n = 1'b1;
        step(1);
    endtask

    task automatic write_en(input logic [5:0] v);
        cfg_wdata = v; cfg_we = 1'b1; step(1); cfg_we = 1'b0;
    endtask

    task automatic enter_stop();
        sleep_req = 1'b1; step(1); sleep_req = 1'b0;
    endtask

    // source numbering: 0..15 IRQ, 16 NMI, 17 INIT, 18..21 PME bits
    task automatic drive_src(input int s);
        if (s < 16)      irq_req[s] = 1'b1;
        else if (s == 16) nmi_req = 1'b1;
        else if (s == 17) init_req = 1'b1;
        else             pme_req[s-18] = 1'b1;
    endtask

    function automatic bit exp_wake(input int s, input logic [5:0] en);
        if (s == 0)      return en[0];
        if (s == 2)      return 1'b0;
        if (s == 8)      return en[5];
        if (s < 18)      return en[1];
        return en[4];
    endfunction

    function automatic string tag_of(input int s);
        if (s == 0)  return "R3";
        if (s == 8)  return "R5";
        if (s < 18)  return "R4";
        return "R6";
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        do_reset();
        // R1: reset state
        chk(stpclk_o == 0, "R1 stpclk", stpclk_o, 0);
        chk(wake_o == 0, "R1 wake", wake_o, 0);
        chk(gst_expire_o == 0, "R1 expire", gst_expire_o, 0);
        chk(cfg_rdata == 0, "R1 cfg", cfg_rdata, 0);
        chk(gst_count_o == 0, "R1 count", gst_count_o, 0);

        // R8: enable readback over all codes
        for (int e = 0; e < 64; e++) begin
            write_en(6'(e));
            chk(cfg_rdata == (6'(e) & 6'b110111), "R8 readback", cfg_rdata, e & 6'h37);
        end

        // R3 R4 R5 R6 R7 R9: all enable codes x all sources
        for (int e = 0; e < 64; e++) begin
            for (int s = 0; s < 22; s++) begin
                bit w;
                w = exp_wake(s, 6'(e));
                do_reset();
                write_en(6'(e));
                enter_stop();
                chk(stpclk_o == 1, "R2 enter", stpclk_o, 1);
                drive_src(s);
                step(2);
                chk(stpclk_o == 1, "R9 latency", stpclk_o, 1);
                step(1);
                chk(stpclk_o == !w, w ? tag_of(s) : "R7 stay", stpclk_o, !w);
                chk(wake_o == w, "R9 wake pulse", wake_o, w);
                step(1);
                chk(wake_o == 0, "R9 pulse width", wake_o, 0);
                chk(stpclk_o == !w, "R2 level", stpclk_o, !w);
                clear_src();
            end
        end

        // R7: masked lines never break, even with all classes enabled
        for (int i = 0; i < 16; i++) begin
            do_reset();
            write_en(6'h37);
            irq_mask = 16'h1 << i;
            enter_stop();
            irq_req[i] = 1'b1;
            step(5);
            chk(stpclk_o == 1, "R7 masked", stpclk_o, 1);
            chk(wake_o == 0, "R7 masked wake", wake_o, 0);
            clear_src();
        end

        // R12: events while running
        do_reset();
        write_en(6'h37);
        irq_req = 16'hFFFF; pme_req = 4'hF; nmi_req = 1;
        for (int k = 0; k < 6; k++) begin
            step(1);
            chk(wake_o == 0 && stpclk_o == 0, "R12 running", {stpclk_o, wake_o}, 0);
        end
        clear_src();

        // R11: countdown and expiry
        do_reset();
        tmr_wdata = 16'd6; tmr_we = 1; step(1); tmr_we = 0;
        for (int k = 0; k <= 8; k++) begin
            int ec;
            ec = (k >= 6) ? 0 : 6 - k;
            chk(gst_count_o == TW'(ec), "R11 count", gst_count_o, ec);
            chk(gst_expire_o == (k == 6), "R11 expire", gst_expire_o, k == 6);
            step(1);
        end

        // R10: keyboard/mouse reload holds the counter; no break
        for (int v = 0; v < 2; v++) begin
            int line;
            line = (v == 0) ? 1 : 12;
            do_reset();
            write_en(6'h04);
            tmr_wdata = 16'd10; tmr_we = 1; step(1); tmr_we = 0;
            enter_stop();
            irq_req[line] = 1'b1;
            step(20);
            chk(gst_count_o == 16'd10, "R10 reload hold", gst_count_o, 10);
            chk(stpclk_o == 1, "R10 no break", stpclk_o, 1);
            clear_src();
            step(20);
            chk(gst_count_o == 0, "R10 runs down", gst_count_o, 0);
        end

        // R10: bit 2 clear, activity does not reload
        do_reset();
        tmr_wdata = 16'd10; tmr_we = 1; step(1); tmr_we = 0;
        irq_req[1] = 1'b1;
        step(15);
        chk(gst_count_o == 0, "R10 disabled", gst_count_o, 0);
        clear_src();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule